// File: doc/BRIEF.md
# Satellite Ranging Code Generator

This block produces the 1023-chip Gold ranging sequence for one selectable satellite. It runs on a 10.23 MHz reference clock and counts that clock down by ten to form a 1.023 MHz chip rate. Each chip period advances two 10-bit maximal-length shift registers. The output chip is the last stage of the first register XORed with two stages of the second register, and the satellite number picks those two stages.

A load strobe takes a new satellite number and restarts the sequence at chip 0. While the generator runs, the satellite input is ignored. Every produced chip is marked by a one-cycle valid strobe. The first chip of each code period also raises an epoch flag, which downstream correlators use as a code-phase reference.

Top module: `ranging_code_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `chip_valid`, `epoch` and `chip_out` are 0. Reset selects satellite 1, which is `sat_sel` value 0.
- R2: After a restart (a reset release or a load), `chip_valid` is first seen high after the 10th rising edge. From then on it is high for exactly one cycle in every 10.
- R3: The first register feeds back stages 3 and 10. The second register feeds back stages 2, 3, 6, 8, 9 and 10. Stage 1 takes the feedback and stage 10 is the output end. The chip is stage 10 of the first register XORed with two stages of the second register, taken from the satellite table (`sat_sel` value k selects satellite k+1). The table pairs for satellites 1 to 32 are: (2,6) (3,7) (4,8) (5,9) (1,9) (2,10) (1,8) (2,9) (3,10) (2,3) (3,4) (5,6) (6,7) (7,8) (8,9) (9,10) (1,4) (2,5) (3,6) (4,7) (5,8) (6,9) (1,3) (4,6) (5,7) (6,8) (7,9) (8,10) (1,6) (2,7) (3,8) (4,9).
- R4: Both registers start from all ones. With the first chip taken as the most significant bit, the first ten chips read 1440, 1620, 1710 and 1744 in octal for satellites 1 to 4.
- R5: The code repeats every 1023 chips. `epoch` is high together with `chip_valid` on chip 0 of every period and is low at all other times.
- R6: A change of `sat_sel` while `load` is low has no effect on the chip stream.
- R7: A `load` restarts the divider, both registers and the chip index, and latches `sat_sel`. It clears `chip_valid` and `epoch` in the next cycle, even when a chip would have been produced on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10.23 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Latch satellite number and restart at chip 0 |
| sat_sel | input | 5 | Satellite number minus one |
| chip_out | output | 1 | Current code chip, held between strobes |
| chip_valid | output | 1 | One-cycle strobe per produced chip |
| epoch | output | 1 | High with the strobe of chip 0 |

## Verification
Two things can land on the same edge: a load strobe and the divider's chip tick. The bench provokes this by counting cycles since the last restart and raising `load` exactly on the edge where the tenth count would fire. It then expects no strobe in the following cycle, and a fresh chip 0 with `epoch` ten edges later under the newly latched satellite. The period wrap, where the registers reload as the epoch falls due, is judged over full sweeps of 2047 chips against an arithmetic model of both registers kept in the bench.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
  } tap_pair_t;

  // stage numbers are 1-based; returned as 0-based bit indices
  function automatic tap_pair_t sat_taps(input logic [4:0] s);
    int x, y;
    case (s)
      5'd0:  begin x = 2; y = 6;  end
      5'd1:  begin x = 3; y = 7;  end
      5'd2:  begin x = 4; y = 8;  end
      5'd3:  begin x = 5; y = 9;  end
      5'd4:  begin x = 1; y = 9;  end
      5'd5:  begin x = 2; y = 10; end
      5'd6:  begin x = 1; y = 8;  end
      5'd7:  begin x = 2; y = 9;  end
      5'd8:  begin x = 3; y = 10; end
      5'd9:  begin x = 2; y = 3;  end
      5'd10: begin x = 3; y = 4;  end
      5'd11: begin x = 5; y = 6;  end
      5'd12: begin x = 6; y = 7;  end
      5'd13: begin x = 7; y = 8;  end
      5'd14: begin x = 8; y = 9;  end
      5'd15: begin x = 9; y = 10; end
      5'd16: begin x = 1; y = 4;  end
      5'd17: begin x = 2; y = 5;  end
      5'd18: begin x = 3; y = 6;  end
      5'd19: begin x = 4; y = 7;  end
      5'd20: begin x = 5; y = 8;  end
      5'd21: begin x = 6; y = 9;  end
      5'd22: begin x = 1; y = 3;  end
      5'd23: begin x = 4; y = 6;  end
      5'd24: begin x = 5; y = 7;  end
      5'd25: begin x = 6; y = 8;  end
      5'd26: begin x = 7; y = 9;  end
      5'd27: begin x = 8; y = 10; end
      5'd28: begin x = 1; y = 6;  end
      5'd29: begin x = 2; y = 7;  end
      5'd30: begin x = 3; y = 8;  end
      default: begin x = 4; y = 9; end
    endcase
    sat_taps.a = 4'(x - 1);
    sat_taps.b = 4'(y - 1);
  endfunction
endpackage

// File: rtl/rcg_chip_divider.sv
module rcg_chip_divider #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rcg_lfsr.sv
module rcg_lfsr #(
  parameter int          W       = 10,
  parameter logic [W-1:0] FB_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] state
);
  // bit i holds stage i+1; stage 1 receives the feedback
  always_ff @(posedge clk) begin
    if (rst || restart || (step && reload)) state <= '1;
    else if (step)                          state <= {state[W-2:0], ^(state & FB_MASK)};
  end
endmodule

// File: rtl/rcg_phase_sel.sv
module rcg_phase_sel #(
  parameter int SAT_W = 5,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SAT_W-1:0] sat_in,
  output logic [IDX_W-1:0] tap_a,
  output logic [IDX_W-1:0] tap_b
);
  import rcg_pkg::*;
  tap_pair_t sel;

  always_comb sel = sat_taps(5'(sat_in));

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_a <= IDX_W'(1);
      tap_b <= IDX_W'(5);
    end else if (load) begin
      tap_a <= IDX_W'(sel.a);
      tap_b <= IDX_W'(sel.b);
    end
  end
endmodule

// File: rtl/ranging_code_gen.sv
module ranging_code_gen #(
  parameter int           DIV     = 10,
  parameter int           REG_W   = 10,
  parameter int           SAT_W   = 5,
  parameter logic [REG_W-1:0] G1_FB = 10'h204,
  parameter logic [REG_W-1:0] G2_FB = 10'h3A6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SAT_W-1:0] sat_sel,
  output logic             chip_out,
  output logic             chip_valid,
  output logic             epoch
);
  localparam int CODE_LEN = (1 << REG_W) - 1;
  localparam int IDX_W    = $clog2(REG_W);

  logic             tick, step, wrap;
  logic [REG_W-1:0] g1, g2, idx;
  logic [IDX_W-1:0] tap_a, tap_b;

  rcg_chip_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .restart(load), .tick(tick)
  );

  assign step = tick && !load;
  assign wrap = (idx == REG_W'(CODE_LEN - 1));

  rcg_lfsr #(.W(REG_W), .FB_MASK(G1_FB)) u_g1 (
    .clk(clk), .rst(rst), .restart(load), .step(step), .reload(wrap), .state(g1)
  );

  rcg_lfsr #(.W(REG_W), .FB_MASK(G2_FB)) u_g2 (
    .clk(clk), .rst(rst), .restart(load), .step(step), .reload(wrap), .state(g2)
  );

  rcg_phase_sel #(.SAT_W(SAT_W), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .load(load), .sat_in(sat_sel), .tap_a(tap_a), .tap_b(tap_b)
  );

  always_ff @(posedge clk) begin
    if (rst || load) idx <= '0;
    else if (step)   idx <= wrap ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      chip_out   <= 1'b0;
      chip_valid <= 1'b0;
      epoch      <= 1'b0;
    end else begin
      chip_valid <= step;
      epoch      <= step && (idx == '0);
      if (step) chip_out <= g1[REG_W-1] ^ g2[tap_a] ^ g2[tap_b];
    end
  end
endmodule

// File: rtl/rcg_check.sv
module rcg_check #(
  parameter int DIV      = 10,
  parameter int CODE_LEN = 1023
) (
  input logic clk,
  input logic rst,
  input logic load,
  input logic chip_valid,
  input logic epoch
);
  localparam int GW = $clog2(DIV + 2) + 1;
  localparam int CW = $clog2(CODE_LEN + 1);
  logic [GW-1:0] gap;
  logic [CW-1:0] chips;

  always_ff @(posedge clk) begin
    if (rst || load)      gap <= '0;
    else if (chip_valid)  gap <= GW'(1);
    else if (gap != '1)   gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || load)     chips <= '0;
    else if (chip_valid) chips <= (chips == CW'(CODE_LEN - 1)) ? '0 : chips + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !chip_valid && !epoch);
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst) chip_valid |=> !chip_valid);
  a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (rst) chip_valid |-> gap == GW'(DIV));
  a_r5_epoch_on_strobe: assert property (@(posedge clk) disable iff (rst) epoch |-> chip_valid);
  a_r5_epoch_chip_zero: assert property (@(posedge clk) disable iff (rst) chip_valid |-> (epoch == (chips == '0)));
  a_r7_load_clears: assert property (@(posedge clk) disable iff (rst) load |=> !chip_valid && !epoch);
endmodule

bind ranging_code_gen rcg_check #(.DIV(DIV), .CODE_LEN((1 << REG_W) - 1)) u_rcg_check (
  .clk(clk), .rst(rst), .load(load), .chip_valid(chip_valid), .epoch(epoch)
);

// File: tb/test_ranging_code_gen.sv
module test_ranging_code_gen;
  localparam int PERIOD = 10;
  localparam int DIV    = 10;
  localparam int LEN    = 1023;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [4:0] sat_sel = '0;
  logic       chip_out, chip_valid, epoch;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model: stages 1..10
  logic [1:10] m1, m2;
  int m_idx, m_sat, cyc, epochs;
  logic [9:0] first10;
  int nchips;

  always #(PERIOD/2) clk = ~clk;

  ranging_code_gen i_ranging_code_gen (
    .clk(clk), .rst(rst), .load(load), .sat_sel(sat_sel),
    .chip_out(chip_out), .chip_valid(chip_valid), .epoch(epoch)
  );

  function automatic int tap_x(int s);
    int t[32] = '{2,3,4,5,1,2,1,2,3,2,3,5,6,7,8,9,1,2,3,4,5,6,1,4,5,6,7,8,1,2,3,4};
    return t[s];
  endfunction
  function automatic int tap_y(int s);
    int t[32] = '{6,7,8,9,9,10,8,9,10,3,4,6,7,8,9,10,4,5,6,7,8,9,3,6,7,8,9,10,6,7,8,9};
    return t[s];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_restart(int s);
    m1 = '1; m2 = '1; m_idx = 0; m_sat = s; cyc = 0; epochs = 0; nchips = 0; first10 = '0;
  endtask

  // advance n edges, comparing at each negedge
  task automatic run(int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc++;
      if ((cyc % DIV) == 0) begin
        logic ec;
        ec = m1[10] ^ m2[tap_x(m_sat)] ^ m2[tap_y(m_sat)];
        chk(chip_valid == 1'b1, "R2", chip_valid, 1);
        chk(chip_out == ec, req, chip_out, ec);
        chk(epoch == (m_idx == 0), "R5", epoch, m_idx == 0);
        if (epoch) epochs++;
        if (nchips < 10) first10 = {first10[8:0], chip_out};
        nchips++;
        if (m_idx == LEN - 1) begin
          m1 = '1; m2 = '1; m_idx = 0;
        end else begin
          m1 = {m1[3] ^ m1[10], m1[1:9]};
          m2 = {m2[2] ^ m2[3] ^ m2[6] ^ m2[8] ^ m2[9] ^ m2[10], m2[1:9]};
          m_idx++;
        end
      end else begin
        if (chip_valid || epoch) chk(1'b0, "R2", chip_valid, 0);
      end
    end
  endtask

  task automatic do_load(int s);
    @(negedge clk);
    load = 1'b1; sat_sel = 5'(s);
    @(negedge clk);
    load = 1'b0;
    chk(!chip_valid && !epoch, "R7", chip_valid, 0);
    model_restart(s);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    sat_sel = 5'd9;
    repeat (3) @(negedge clk);
    chk(!chip_valid && !epoch && !chip_out, "R1", chip_valid, 0);
    rst = 1'b0;
    // reset selects satellite 1 although sat_sel is 9
    model_restart(0);
    @(negedge clk); cyc++;
    chk(!chip_valid && !epoch && !chip_out, "R1", chip_valid, 0);
    run(99, "R1");
    chk(first10 == 10'o1440, "R4", first10, 10'o1440);

    // octal first-ten patterns for satellites 2..4
    for (int s = 1; s < 4; s++) begin
      int expv;
      expv = (s == 1) ? 10'o1620 : (s == 2) ? 10'o1710 : 10'o1744;
      do_load(s);
      run(100, "R3");
      chk(first10 == 10'(expv), "R4", first10, expv);
    end

    // every satellite, first 16 chips
    for (int s = 0; s < 32; s++) begin
      do_load(s);
      run(160, "R3");
    end

    // two full periods plus one chip: three epochs
    do_load(0);
    run((2 * LEN + 1) * DIV, "R5");
    chk(epochs == 3, "R5", epochs, 3);

    // sat_sel change without load is ignored
    do_load(4);
    run(300, "R6");
    sat_sel = 5'd20;
    run(600, "R6");

    // load coinciding with a chip tick: run to cyc%DIV==DIV-2 then load
    do_load(7);
    run(DIV * 5 + DIV - 2, "R7");
    do_load(12);
    run(40 * DIV, "R7");
    chk(epochs == 1, "R7", epochs, 1);

    // load on the wrap edge of a full period
    do_load(30);
    run(LEN * DIV - 2, "R5");
    do_load(30);
    run(20 * DIV, "R5");

    // reset mid-run returns to satellite 1
    sat_sel = 5'd7;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(!chip_valid && !epoch, "R1", chip_valid, 0);
    rst = 1'b0;
    model_restart(0);
    run(100, "R1");
    chk(first10 == 10'o1440, "R1", first10, 10'o1440);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule